// File: doc/BRIEF.md
# Dual-Port Same-Word Contention Arbiter

This block sits beside a shared two-port RAM array and resolves the case where the left and right ports reach for the same word at once. Each port brings an enable, a write strobe and a word address. The block returns a registered, active-low busy flag to each port and a write-block signal per port that goes to the array. When a port's write-block is high, the array must drop that port's write. A losing port may still read.

A mode pin selects the role. As a master, the block detects matching addresses and picks a winner. It drives the result on its busy outputs. As a slave, it does not arbitrate. It samples busy flags supplied by a master and applies them to its own write path. Several devices can then act as one wider word under a single decision. A slave holds back writes for the opening cycles of each access, so the imported busy has time to arrive before any write is committed.

Top module: `dp_contention_arb`

## Requirements
- R1: In master mode, when the two ports do not both have their enable high on equal addresses, both busy outputs read 1 one cycle later and neither write-block is raised.
- R2: In master mode, when both ports arrive on the same address in the same cycle, the left port wins. The right write-block is high in that cycle, and one cycle later right busy reads 0 and left busy reads 1.
- R3: In master mode the two busy outputs are never 0 together, and the two write-blocks are never high together.
- R4: A port that was enabled on an address in the previous cycle keeps it against a port that moves onto that address. It keeps it for as long as the contention lasts, and on either side.
- R5: When a port's enable rises onto an address that the other enabled port already holds, the arriving port loses. Its busy reads 0 one cycle later.
- R6: Busy outputs are registered. A busy that is 0 stays 0 through the cycle in which the contention ends and reads 1 in the cycle after.
- R7: A losing port with its write strobe low (a read) sees its write-block low, while its busy is still asserted.
- R8: In slave mode the block does not arbitrate. Each busy output equals that port's busy input as sampled on the previous clock edge.
- R9: In slave mode, a write is blocked in the first two cycles of an access (enable high on an unchanged address). It is also blocked in any cycle whose previous-edge sample of the port's busy input was 0, and in the one cycle after such a sample.
- R10: After reset both busy outputs read 1 and both write-blocks read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = import busy |
| l_en | input | 1 | Left port access enable |
| l_wr | input | 1 | Left port write strobe (1 = write) |
| l_addr | input | ADDR_W | Left port word address |
| r_en | input | 1 | Right port access enable |
| r_wr | input | 1 | Right port write strobe (1 = write) |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_in_n | input | 1 | Left busy from a master, active low (slave mode) |
| r_busy_in_n | input | 1 | Right busy from a master, active low (slave mode) |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_blk | output | 1 | Suppress left write into the array |
| r_wr_blk | output | 1 | Suppress right write into the array |

## Verification
The bench builds the block with its defaults: a 15-bit address and a two-cycle slave settling window. The wide address means matches are decided on the full word, not on a few low bits. The short window lets the bench walk every blocked cycle of a slave write by hand, from first enable through busy release and its one-cycle tail. Directed scenarios cover simultaneous arrival, a port moving onto a held word from either side, an enable rising onto a held word, a losing read, and slave import with no arbitration of its own.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned NPORT = 2;
  localparam int unsigned P_L   = 0;
  localparam int unsigned P_R   = 1;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hold,
  output logic              settled
);
  localparam int unsigned AGE_W = $clog2(SETTLE_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SETTLE_CYC);

  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AGE_W-1:0]  age_q, age_cur, age_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  // access continues from the previous cycle on an unchanged word
  assign hold    = en & en_q & (addr == addr_q);
  assign age_cur = hold ? age_q : '0;
  assign settled = (age_cur >= AGE_MAX);

  always_comb begin
    addr_nxt = addr_q;
    if (en) addr_nxt = addr;
    age_nxt = '0;
    if (en) begin
      if (age_cur == AGE_MAX) age_nxt = AGE_MAX;
      else                    age_nxt = age_cur + AGE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      age_q  <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr_nxt;
      age_q  <= age_nxt;
    end
  end
endmodule

// File: rtl/dpa_master_arb.sv
module dpa_master_arb
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_hold,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_hold,
  output logic              l_lose,
  output logic              r_lose,
  output logic              l_busy_q,
  output logic              r_busy_q
);
  owner_e owner_q, owner_nxt, winner;
  logic   match;

  assign match = l_en & r_en & (l_addr == r_addr);

  always_comb begin
    if      ((owner_q == OWN_RIGHT) && r_hold) winner = OWN_RIGHT;
    else if ((owner_q == OWN_LEFT)  && l_hold) winner = OWN_LEFT;
    else if (r_hold && !l_hold)                winner = OWN_RIGHT;
    else                                       winner = OWN_LEFT;
    owner_nxt = match ? winner : OWN_NONE;
  end

  assign l_lose = match & (winner == OWN_RIGHT);
  assign r_lose = match & (winner == OWN_LEFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      l_busy_q <= 1'b0;
      r_busy_q <= 1'b0;
    end else begin
      owner_q  <= owner_nxt;
      l_busy_q <= l_lose;
      r_busy_q <= r_lose;
    end
  end
endmodule

// File: rtl/dpa_slave_sync.sv
module dpa_slave_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_in_n,
  output logic bsy_now,
  output logic bsy_tail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy_now  <= 1'b0;
      bsy_tail <= 1'b0;
    end else begin
      bsy_now  <= ~busy_in_n;
      bsy_tail <= bsy_now;
    end
  end
endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_blk,
  output logic              r_wr_blk
);
  logic [NPORT-1:0]  en_v, wr_v, bin_n_v;
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic [NPORT-1:0]  hold_v, settled_v, bsy_now_v, bsy_tail_v;
  logic [NPORT-1:0]  lose_v, mbusy_v, busy_n_v, blk_v;

  assign en_v    = {r_en, l_en};
  assign wr_v    = {r_wr, l_wr};
  assign bin_n_v = {r_busy_in_n, l_busy_in_n};
  assign addr_v[P_L] = l_addr;
  assign addr_v[P_R] = r_addr;

  dpa_master_arb #(.ADDR_W(ADDR_W)) u_marb (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_en     (l_en),
    .l_addr   (l_addr),
    .l_hold   (hold_v[P_L]),
    .r_en     (r_en),
    .r_addr   (r_addr),
    .r_hold   (hold_v[P_R]),
    .l_lose   (lose_v[P_L]),
    .r_lose   (lose_v[P_R]),
    .l_busy_q (mbusy_v[P_L]),
    .r_busy_q (mbusy_v[P_R])
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_port_track #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_v[p]),
      .addr    (addr_v[p]),
      .hold    (hold_v[p]),
      .settled (settled_v[p])
    );

    dpa_slave_sync u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_in_n (bin_n_v[p]),
      .bsy_now   (bsy_now_v[p]),
      .bsy_tail  (bsy_tail_v[p])
    );

    logic wr_act;
    assign wr_act = en_v[p] & wr_v[p];

    always_comb begin
      if (master_mode) begin
        busy_n_v[p] = ~mbusy_v[p];
        blk_v[p]    = wr_act & lose_v[p];
      end else begin
        busy_n_v[p] = ~bsy_now_v[p];
        blk_v[p]    = wr_act & (~settled_v[p] | bsy_now_v[p] | bsy_tail_v[p]);
      end
    end
  end

  assign l_busy_n = busy_n_v[P_L];
  assign r_busy_n = busy_n_v[P_R];
  assign l_wr_blk = blk_v[P_L];
  assign r_wr_blk = blk_v[P_R];
endmodule

// File: rtl/dpa_arb_checker.sv
module dpa_arb_checker #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_en,
  input logic              l_wr,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_en,
  input logic              r_wr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_in_n,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_blk,
  input logic              r_wr_blk
);
  logic same_word;
  assign same_word = l_en & r_en & (l_addr == r_addr);

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> (l_busy_n || r_busy_n)); // R3

  AST_ONE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> !(l_wr_blk && r_wr_blk)); // R3

  AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !same_word) |=> (!master_mode || (l_busy_n && r_busy_n))); // R1

  AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && same_word) |=> (!master_mode || (l_busy_n != r_busy_n))); // R4

  AST_READ_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_wr_blk && !l_wr) && !(r_wr_blk && !r_wr)); // R7

  AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !l_busy_in_n) |=> (master_mode || !l_busy_n)); // R8

  AST_SLAVE_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !r_busy_in_n) |=> (master_mode || !(r_en && r_wr) || r_wr_blk)); // R9
endmodule

bind dp_contention_arb dpa_arb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .master_mode (master_mode),
  .l_en        (l_en),
  .l_wr        (l_wr),
  .l_addr      (l_addr),
  .r_en        (r_en),
  .r_wr        (r_wr),
  .r_addr      (r_addr),
  .l_busy_in_n (l_busy_in_n),
  .r_busy_in_n (r_busy_in_n),
  .l_busy_n    (l_busy_n),
  .r_busy_n    (r_busy_n),
  .l_wr_blk    (l_wr_blk),
  .r_wr_blk    (r_wr_blk)
);

// File: tb/dp_contention_arb_bench.sv
`timescale 1ns/1ps
module dp_contention_arb_bench;
  localparam int unsigned AW = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          master_mode;
  logic          l_en, l_wr, r_en, r_wr;
  logic [AW-1:0] l_addr, r_addr;
  logic          l_busy_in_n, r_busy_in_n;
  logic          l_busy_n, r_busy_n, l_wr_blk, r_wr_blk;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dp_contention_arb u_dp_contention_arb (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
    .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_blk(l_wr_blk), .r_wr_blk(r_wr_blk)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // advance to just after the next rising edge
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic go_idle();
    l_en = 0; r_en = 0; l_wr = 0; r_wr = 0;
    l_busy_in_n = 1; r_busy_in_n = 1;
    cyc(); cyc();
  endtask

  task automatic t_reset();
    chk("R10", "l_busy_n", l_busy_n, 1'b1);
    chk("R10", "r_busy_n", r_busy_n, 1'b1);
    chk("R10", "l_wr_blk", l_wr_blk, 1'b0);
    chk("R10", "r_wr_blk", r_wr_blk, 1'b0);
  endtask

  task automatic t_no_contention();
    master_mode = 1;
    go_idle();
    l_en = 1; l_wr = 1; l_addr = 15'h0100;
    r_en = 1; r_wr = 1; r_addr = 15'h0101;
    settle();
    chk("R1", "l_wr_blk distinct addr", l_wr_blk, 1'b0);
    chk("R1", "r_wr_blk distinct addr", r_wr_blk, 1'b0);
    cyc();
    chk("R1", "l_busy_n distinct addr", l_busy_n, 1'b1);
    chk("R1", "r_busy_n distinct addr", r_busy_n, 1'b1);
  endtask

  task automatic t_tie();
    go_idle();
    l_en = 1; l_wr = 1; l_addr = 15'h7FFF;
    r_en = 1; r_wr = 1; r_addr = 15'h7FFF;
    settle();
    chk("R2", "r_wr_blk tie", r_wr_blk, 1'b1);
    chk("R2", "l_wr_blk tie", l_wr_blk, 1'b0);
    cyc();
    chk("R2", "r_busy_n tie", r_busy_n, 1'b0);
    chk("R2", "l_busy_n tie", l_busy_n, 1'b1);
    chk("R3", "not both busy", l_busy_n | r_busy_n, 1'b1);
    // contention ends: right drops enable
    r_en = 0;
    settle();
    chk("R6", "r_busy_n holds in end cycle", r_busy_n, 1'b0);
    cyc();
    chk("R6", "r_busy_n released", r_busy_n, 1'b1);
  endtask

  task automatic t_holder();
    go_idle();
    l_en = 1; l_wr = 0; l_addr = 15'h0005;
    r_en = 1; r_wr = 0; r_addr = 15'h0009;
    cyc();
    r_addr = 15'h0005; r_wr = 1;
    settle();
    chk("R4", "mover right blocked", r_wr_blk, 1'b1);
    cyc();
    chk("R4", "r_busy_n mover", r_busy_n, 1'b0);
    chk("R4", "l_busy_n holder", l_busy_n, 1'b1);
    cyc();
    chk("R4", "r_busy_n still lost", r_busy_n, 1'b0);
    // right now reads while losing
    r_wr = 0;
    settle();
    chk("R7", "losing read not blocked", r_wr_blk, 1'b0);
    chk("R7", "losing read still busy", r_busy_n, 1'b0);
    // mirror: right holds, left moves on
    go_idle();
    r_en = 1; r_wr = 0; r_addr = 15'h0007;
    l_en = 1; l_wr = 0; l_addr = 15'h0002;
    cyc();
    l_addr = 15'h0007; l_wr = 1;
    settle();
    chk("R4", "mover left blocked", l_wr_blk, 1'b1);
    chk("R4", "holder right free", r_wr_blk, 1'b0);
    cyc();
    chk("R4", "l_busy_n mover", l_busy_n, 1'b0);
    chk("R4", "r_busy_n holder", r_busy_n, 1'b1);
  endtask

  task automatic t_enable_arrival();
    go_idle();
    r_en = 1; r_wr = 1; r_addr = 15'h1234;
    l_en = 0; l_wr = 1; l_addr = 15'h1234;
    cyc();
    l_en = 1;
    settle();
    chk("R5", "arriving left blocked", l_wr_blk, 1'b1);
    cyc();
    chk("R5", "l_busy_n arrival", l_busy_n, 1'b0);
    chk("R5", "r_busy_n holder", r_busy_n, 1'b1);
  endtask

  task automatic t_slave_follow();
    go_idle();
    master_mode = 0;
    go_idle();
    l_en = 1; l_wr = 0; l_addr = 15'h0040;
    r_en = 1; r_wr = 0; r_addr = 15'h0040;
    cyc();
    chk("R8", "slave no own arb l", l_busy_n, 1'b1);
    chk("R8", "slave no own arb r", r_busy_n, 1'b1);
    r_busy_in_n = 0;
    settle();
    chk("R8", "r_busy_n before sample", r_busy_n, 1'b1);
    cyc();
    chk("R8", "r_busy_n follows input", r_busy_n, 1'b0);
    chk("R8", "l_busy_n unaffected", l_busy_n, 1'b1);
    r_busy_in_n = 1;
    cyc();
    chk("R8", "r_busy_n releases", r_busy_n, 1'b1);
  endtask

  task automatic t_slave_settle();
    master_mode = 0;
    go_idle();
    l_en = 1; l_wr = 1; l_addr = 15'h0333;
    settle();
    chk("R9", "slave write cycle0 blocked", l_wr_blk, 1'b1);
    cyc();
    chk("R9", "slave write cycle1 blocked", l_wr_blk, 1'b1);
    cyc();
    chk("R9", "slave write cycle2 open", l_wr_blk, 1'b0);
    l_busy_in_n = 0;
    cyc();
    chk("R9", "blocked on sampled busy", l_wr_blk, 1'b1);
    l_busy_in_n = 1;
    cyc();
    chk("R9", "blocked in tail cycle", l_wr_blk, 1'b1);
    cyc();
    chk("R9", "open after tail", l_wr_blk, 1'b0);
    // a fresh address restarts the settling window
    l_addr = 15'h0334;
    settle();
    chk("R9", "new address blocked", l_wr_blk, 1'b1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; master_mode = 1;
    l_en = 0; l_wr = 0; l_addr = '0;
    r_en = 0; r_wr = 0; r_addr = '0;
    l_busy_in_n = 1; r_busy_in_n = 1;
    cyc(); cyc();
    t_reset();
    rst_n = 1;
    cyc();
    t_reset();
    t_no_contention();
    t_tie();
    t_holder();
    t_enable_arrival();
    t_slave_follow();
    t_slave_settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule